// File: doc/BRIEF.md
# Wait-State Aware Expansion-Bus Cycle Engine

This block connects a fast host, whose every access completes in one clock, to a slow 8-bit expansion bus whose cards may stretch any access with a ready line. The host drops an access into the bridge window. The engine records the access kind, the low address byte and the write data. It waits until the host marks an opcode fetch, which shows that the instruction that made the access has finished. It then runs one self-timed bus cycle. The strobe stays low for as many clocks as the card holds its ready line low. The host never stalls.

The access kind comes from host address bit 8 and the read/write flag. Bit 8 high selects the memory space and low selects the I/O space, so the four combinations give memory read, memory write, I/O read and I/O write. Read data does not return directly: it is captured into a holding register that the host fetches with a second access. The block also merges six card interrupt lines into one active-low host interrupt. A rising edge on any line sets the interrupt, and any completed bridged read clears it.

The controller has four state encodings:
- ST_IDLE goes to ST_STROBE when an access is pending and the opcode-fetch marker is high.
- ST_STROBE stays while ready is low, and goes to ST_TERM when ready is high.
- ST_TERM always goes to ST_IDLE.
- ST_SPARE is never entered and falls back to ST_IDLE.

Top module: `isa_cycle_engine`

## Requirements
- R1: While rst_n is low, all four strobes and cyc_clr_n are high, isa_dout_en is low and host_irq_n is high.
- R2: A cycle starts only from ST_IDLE, with an access pending from an earlier acc_sel clock and fetch_mark high. The strobe goes low in the clock after that edge. fetch_mark with nothing pending starts nothing.
- R3: While idle and not starting, each acc_sel clock replaces the recorded access, so the last access before the opcode fetch is the one performed. An earlier false access is discarded.
- R4: In ST_STROBE exactly one strobe is low: acc_a8=1 with acc_rnw=1 gives memr_n, 1/0 gives memw_n, 0/1 gives ior_n, and 0/0 gives iow_n. Outside ST_STROBE all four strobes are high.
- R5: The strobe lasts at least one clock and stays low through every clock in which iochrdy is sampled low (0 = not ready).
- R6: The clock after the last strobe clock (ST_TERM) has all strobes high and cyc_clr_n low for exactly one clock, then the engine is idle again.
- R7: For a read, isa_din sampled in the final strobe clock appears on rd_hold from the ST_TERM clock on. rd_hold is unchanged by writes.
- R8: isa_addr is {addr_hi, addr_mid, recorded low byte}, with addr_hi on bits 19:16, addr_mid on bits 15:8 and the low byte on bits 7:0.
- R9: isa_dout_en is high only in ST_STROBE of a write, and isa_dout then carries the recorded write data.
- R10: A rising edge on any irq_in line (low at one clock edge, high at the next) drives host_irq_n low from that next edge on.
- R11: Completing a read cycle clears the interrupt at the edge that leaves ST_STROBE, but a new edge in that same clock wins. Write cycles do not clear it.
- R12: acc_sel is ignored in ST_STROBE and ST_TERM, and in the clock in which a cycle starts.
- R13: isa_reset is high exactly while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Host reset, active low |
| acc_sel | input | 1 | Host access falls in the bridge window this clock |
| fetch_mark | input | 1 | Host is fetching an opcode this clock |
| acc_rnw | input | 1 | Access direction, 1 = read |
| acc_a8 | input | 1 | Space select, 1 = memory, 0 = I/O |
| acc_lo | input | 8 | Low address byte of the access |
| acc_wdata | input | 8 | Write data of the access |
| addr_hi | input | 4 | Upper address bits 19:16 from the host register |
| addr_mid | input | 8 | Middle address bits 15:8 from the host register |
| iochrdy | input | 1 | Card ready, 0 stretches the strobe |
| isa_din | input | 8 | Data from the card bus |
| irq_in | input | 6 | Card interrupt lines, active high |
| isa_addr | output | 20 | Bus address |
| isa_dout | output | 8 | Write data towards the card bus |
| isa_dout_en | output | 1 | Write data drive enable |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| cyc_clr_n | output | 1 | End-of-cycle clear pulse, active low |
| rd_hold | output | 8 | Read holding register |
| host_irq_n | output | 1 | Merged host interrupt, active low |
| isa_reset | output | 1 | Card bus reset, active high |

## Verification
The strobe, cyc_clr_n and isa_dout_en follow the state register, so they change in the clock after the edge that moves the state. rd_hold and host_irq_n change one edge after the clock in which isa_din or irq_in is sampled, and isa_addr follows the recorded low byte from the edge after acc_sel. The bench drives inputs 1 ns after each rising edge and compares at the falling edge. Its behavioural model advances at each rising edge, so each result is checked in the first clock it is due. Directed sequences add checks at fixed offsets: the first strobe clock after the fetch edge, every stretched clock, the single ST_TERM clock, and the idle clock after it.

// File: rtl/isa_eng_pkg.sv
package isa_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_TERM   = 2'd2,
        ST_SPARE  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/isa_eng_fsm.sv
module isa_eng_fsm
    import isa_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       fetch_mark,
    input  logic       rdy,
    output eng_state_t state,
    output logic       take,
    output logic       finish
);
    eng_state_t nxt;
    logic       pend_q;
    logic       start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend_q <= 1'b0;
        end else begin
            state <= nxt;
            if (start)
                pend_q <= 1'b0;
            else if (take)
                pend_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (pend_q && fetch_mark) nxt = ST_STROBE;
            ST_STROBE: if (rdy) nxt = ST_TERM;
            ST_TERM:   nxt = ST_IDLE;
            ST_SPARE:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start  = (state == ST_IDLE) && pend_q && fetch_mark;
        take   = (state == ST_IDLE) && sel && !start;
        finish = (state == ST_STROBE) && rdy;
    end

endmodule

// File: rtl/isa_eng_latch.sv
module isa_eng_latch #(
    parameter int LO_W = 8,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            rnw_in,
    input  logic            a8_in,
    input  logic [LO_W-1:0] lo_in,
    input  logic [DW-1:0]   wd_in,
    input  logic            capture,
    input  logic [DW-1:0]   din,
    output logic            rnw_q,
    output logic            a8_q,
    output logic [LO_W-1:0] lo_q,
    output logic [DW-1:0]   wd_q,
    output logic [DW-1:0]   rd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnw_q <= 1'b1;
            a8_q  <= 1'b0;
            lo_q  <= '0;
            wd_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (take) begin
                rnw_q <= rnw_in;
                a8_q  <= a8_in;
                lo_q  <= lo_in;
                wd_q  <= wd_in;
            end
            if (capture)
                rd_q <= din;
        end
    end
endmodule

// File: rtl/isa_eng_irq.sv
module isa_eng_irq #(
    parameter int NIRQ = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_in,
    input  logic            clr,
    output logic            irq_q
);
    logic [NIRQ-1:0] prev_q;
    logic [NIRQ-1:0] edge_v;

    for (genvar g = 0; g < NIRQ; g++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= irq_in[g];
        end
        assign edge_v[g] = irq_in[g] & ~prev_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (|edge_v)
            irq_q <= 1'b1;
        else if (clr)
            irq_q <= 1'b0;
    end
endmodule

// File: rtl/isa_cycle_engine.sv
module isa_cycle_engine
    import isa_eng_pkg::*;
#(
    parameter int LO_W  = 8,
    parameter int MID_W = 8,
    parameter int HI_W  = 4,
    parameter int DW    = 8,
    parameter int NIRQ  = 6,
    localparam int AW   = HI_W + MID_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_sel,
    input  logic             fetch_mark,
    input  logic             acc_rnw,
    input  logic             acc_a8,
    input  logic [LO_W-1:0]  acc_lo,
    input  logic [DW-1:0]    acc_wdata,
    input  logic [HI_W-1:0]  addr_hi,
    input  logic [MID_W-1:0] addr_mid,
    input  logic             iochrdy,
    input  logic [DW-1:0]    isa_din,
    input  logic [NIRQ-1:0]  irq_in,
    output logic [AW-1:0]    isa_addr,
    output logic [DW-1:0]    isa_dout,
    output logic             isa_dout_en,
    output logic             memr_n,
    output logic             memw_n,
    output logic             ior_n,
    output logic             iow_n,
    output logic             cyc_clr_n,
    output logic [DW-1:0]    rd_hold,
    output logic             host_irq_n,
    output logic             isa_reset
);
    eng_state_t      state;
    logic            take, finish;
    logic            rnw_q, a8_q;
    logic [LO_W-1:0] lo_q;
    logic            rd_done;
    logic            irq_q;

    isa_eng_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(acc_sel), .fetch_mark(fetch_mark),
        .rdy(iochrdy), .state(state), .take(take), .finish(finish)
    );

    assign rd_done = finish & rnw_q;

    isa_eng_latch #(.LO_W(LO_W), .DW(DW)) u_lat (
        .clk(clk), .rst_n(rst_n), .take(take), .rnw_in(acc_rnw),
        .a8_in(acc_a8), .lo_in(acc_lo), .wd_in(acc_wdata),
        .capture(rd_done), .din(isa_din), .rnw_q(rnw_q), .a8_q(a8_q),
        .lo_q(lo_q), .wd_q(isa_dout), .rd_q(rd_hold)
    );

    isa_eng_irq #(.NIRQ(NIRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(rd_done), .irq_q(irq_q)
    );

    assign isa_addr   = {addr_hi, addr_mid, lo_q};
    assign host_irq_n = ~irq_q;
    assign isa_reset  = ~rst_n;

    // strobe and clear outputs by state
    always_comb begin
        memr_n      = 1'b1;
        memw_n      = 1'b1;
        ior_n       = 1'b1;
        iow_n       = 1'b1;
        isa_dout_en = 1'b0;
        cyc_clr_n   = 1'b1;
        unique case (state)
            ST_STROBE: begin
                memr_n      = !( a8_q &  rnw_q);
                memw_n      = !( a8_q & !rnw_q);
                ior_n       = !(!a8_q &  rnw_q);
                iow_n       = !(!a8_q & !rnw_q);
                isa_dout_en = !rnw_q;
            end
            ST_TERM:  cyc_clr_n = 1'b0;
            ST_IDLE:  ;
            ST_SPARE: ;
        endcase
    end

endmodule

// File: rtl/isa_cycle_engine_chk.sv
module isa_cycle_engine_chk #(
    parameter int NIRQ = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iochrdy,
    input logic [NIRQ-1:0] irq_in,
    input logic            memr_n,
    input logic            memw_n,
    input logic            ior_n,
    input logic            iow_n,
    input logic            cyc_clr_n,
    input logic            isa_dout_en,
    input logic            host_irq_n
);
    logic [3:0] strb;
    assign strb = {memr_n, memw_n, ior_n, iow_n};

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~strb) <= 1);

    a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != 4'hF && !iochrdy) |=> ($stable(strb) && strb != 4'hF));

    a_r6_release_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != 4'hF && iochrdy) |=> (strb == 4'hF && !cyc_clr_n));

    a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_clr_n |=> (cyc_clr_n && strb == 4'hF));

    a_r9_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        isa_dout_en |-> (!memw_n || !iow_n));

    a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_in & ~$past(irq_in))) |=> !host_irq_n);
endmodule

bind isa_cycle_engine isa_cycle_engine_chk #(.NIRQ(NIRQ)) chk_i (
    .clk(clk), .rst_n(rst_n), .iochrdy(iochrdy), .irq_in(irq_in),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .cyc_clr_n(cyc_clr_n), .isa_dout_en(isa_dout_en), .host_irq_n(host_irq_n)
);

// File: tb/isa_cycle_engine_tb_top.sv
`timescale 1ns/100ps
module isa_cycle_engine_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, acc_sel, fetch_mark, acc_rnw, acc_a8, iochrdy;
    logic [7:0]  acc_lo, acc_wdata, addr_mid, isa_din;
    logic [3:0]  addr_hi;
    logic [5:0]  irq_in;
    logic [19:0] isa_addr;
    logic [7:0]  isa_dout, rd_hold;
    logic        isa_dout_en, memr_n, memw_n, ior_n, iow_n, cyc_clr_n;
    logic        host_irq_n, isa_reset;
    logic [3:0]  strb;
    assign strb = {memr_n, memw_n, ior_n, iow_n};

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    isa_cycle_engine dut_i (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .fetch_mark(fetch_mark),
        .acc_rnw(acc_rnw), .acc_a8(acc_a8), .acc_lo(acc_lo), .acc_wdata(acc_wdata),
        .addr_hi(addr_hi), .addr_mid(addr_mid), .iochrdy(iochrdy), .isa_din(isa_din),
        .irq_in(irq_in), .isa_addr(isa_addr), .isa_dout(isa_dout),
        .isa_dout_en(isa_dout_en), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
        .iow_n(iow_n), .cyc_clr_n(cyc_clr_n), .rd_hold(rd_hold),
        .host_irq_n(host_irq_n), .isa_reset(isa_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int         m_st = 0;   // 0 idle, 1 strobing, 2 closing
    bit         m_pend, m_rnw, m_a8, m_irq;
    logic [7:0] m_lo, m_wd, m_rdh;
    logic [5:0] m_prev;

    always @(posedge clk) begin
        bit rdclr;
        rdclr = 0;
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_rnw = 1; m_a8 = 0; m_irq = 0;
            m_lo = 0; m_wd = 0; m_rdh = 0; m_prev = 0;
        end else begin
            if (m_st == 0) begin
                if (m_pend && fetch_mark) begin m_st = 1; m_pend = 0; end
                else if (acc_sel) begin
                    m_pend = 1; m_rnw = acc_rnw; m_a8 = acc_a8;
                    m_lo = acc_lo; m_wd = acc_wdata;
                end
            end else if (m_st == 1) begin
                if (iochrdy) begin
                    if (m_rnw) begin m_rdh = isa_din; rdclr = 1; end
                    m_st = 2;
                end
            end else m_st = 0;
            if (|(irq_in & ~m_prev)) m_irq = 1;
            else if (rdclr) m_irq = 0;
            m_prev = irq_in;
        end
    end

    always @(negedge clk) begin
        logic [3:0] e;
        if (rst_n && !done) begin
            e = 4'hF;
            if (m_st == 1) begin
                if (m_a8 && m_rnw)  e[3] = 1'b0;
                else if (m_a8)      e[2] = 1'b0;
                else if (m_rnw)     e[1] = 1'b0;
                else                e[0] = 1'b0;
            end
            chk("R4 model strobes", strb, e);
            chk("R6 model clear", cyc_clr_n, m_st != 2);
            chk("R9 model drive enable", isa_dout_en, (m_st == 1) && !m_rnw);
            chk("R8 model address", isa_addr, {addr_hi, addr_mid, m_lo});
            chk("R7 model hold", rd_hold, m_rdh);
            chk("R10 model irq", host_irq_n, !m_irq);
        end
    end

    task automatic run_cycle(input bit a8, input bit rnw, input logic [7:0] lo,
                             input logic [7:0] wd, input logic [7:0] din, input int waits);
        logic [3:0] e;
        e = 4'hF;
        if (a8 && rnw)  e[3] = 1'b0;
        else if (a8)    e[2] = 1'b0;
        else if (rnw)   e[1] = 1'b0;
        else            e[0] = 1'b0;
        @(posedge clk); #1;
        acc_sel = 1; acc_a8 = a8; acc_rnw = rnw; acc_lo = lo; acc_wdata = wd; isa_din = din;
        @(posedge clk); #1; acc_sel = 0;
        @(posedge clk); #1; fetch_mark = 1; iochrdy = (waits == 0);
        @(posedge clk); #1; fetch_mark = 0;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk); chk("R5 strobe held while not ready", strb, e);
            @(posedge clk); #1;
            if (i == waits - 1) iochrdy = 1;
        end
        @(negedge clk);
        chk("R2 R4 strobe decode", strb, e);
        chk("R8 bus address", isa_addr, {addr_hi, addr_mid, lo});
        chk("R9 drive enable", isa_dout_en, !rnw);
        if (!rnw) chk("R9 write data", isa_dout, wd);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R6 strobes released", strb, 4'hF);
        chk("R6 clear pulse", cyc_clr_n, 1'b0);
        if (rnw) chk("R7 read hold", rd_hold, din);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R6 clear ends", cyc_clr_n, 1'b1);
    endtask

    initial begin
        rst_n = 0; acc_sel = 0; fetch_mark = 0; acc_rnw = 1; acc_a8 = 0;
        acc_lo = 0; acc_wdata = 0; addr_hi = 4'hA; addr_mid = 8'h5C;
        iochrdy = 1; isa_din = 0; irq_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 strobes in reset", strb, 4'hF);
        chk("R1 clear in reset", cyc_clr_n, 1'b1);
        chk("R1 drive in reset", isa_dout_en, 1'b0);
        chk("R1 irq in reset", host_irq_n, 1'b1);
        chk("R13 bus reset high", isa_reset, 1'b1);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R13 bus reset low", isa_reset, 1'b0);

        // fetch with nothing pending
        @(posedge clk); #1; fetch_mark = 1;
        @(posedge clk); #1; fetch_mark = 0;
        @(negedge clk); chk("R2 no start without access", strb, 4'hF);

        run_cycle(1, 1, 8'h3C, 8'h00, 8'hA5, 0);
        run_cycle(0, 0, 8'h78, 8'h4E, 8'h11, 2);
        chk("R7 hold unchanged by write", rd_hold, 8'hA5);
        run_cycle(1, 0, 8'hC3, 8'h96, 8'h22, 1);
        addr_hi = 4'h3; addr_mid = 8'hE1;
        run_cycle(0, 1, 8'h05, 8'h00, 8'h6B, 3);

        // false early access replaced by the real one
        @(posedge clk); #1; acc_sel = 1; acc_a8 = 0; acc_rnw = 1; acc_lo = 8'h11; isa_din = 8'h7E;
        @(posedge clk); #1; acc_lo = 8'h22;
        @(posedge clk); #1; acc_sel = 0; fetch_mark = 1;
        @(posedge clk); #1; fetch_mark = 0;
        @(negedge clk);
        chk("R3 last access wins", isa_addr[7:0], 8'h22);
        chk("R3 io read strobe", ior_n, 1'b0);
        repeat (3) @(posedge clk); #1;

        // select while busy is ignored
        @(posedge clk); #1; acc_sel = 1; acc_a8 = 1; acc_rnw = 0; acc_lo = 8'h40; acc_wdata = 8'h5A;
        @(posedge clk); #1; acc_sel = 0; fetch_mark = 1; iochrdy = 0;
        @(posedge clk); #1; fetch_mark = 0; acc_sel = 1; acc_lo = 8'h99;
        @(posedge clk); #1; acc_sel = 0;
        @(negedge clk);
        chk("R12 address kept while busy", isa_addr[7:0], 8'h40);
        chk("R5 write strobe stretched", memw_n, 1'b0);
        @(posedge clk); #1; iochrdy = 1;
        repeat (3) @(posedge clk); #1;
        fetch_mark = 1;
        @(posedge clk); #1; fetch_mark = 0;
        @(negedge clk);
        chk("R12 busy select started nothing", strb, 4'hF);

        // interrupt latch
        @(posedge clk); #1; irq_in = 6'b001000;
        @(posedge clk); #1;
        @(negedge clk); chk("R10 edge sets irq", host_irq_n, 1'b0);
        run_cycle(1, 0, 8'h10, 8'h01, 8'h00, 0);
        chk("R11 write keeps irq", host_irq_n, 1'b0);
        run_cycle(0, 1, 8'h20, 8'h00, 8'hC7, 1);
        chk("R11 read clears irq", host_irq_n, 1'b1);
        @(posedge clk); #1; irq_in = 6'b001001;
        @(posedge clk); #1;
        @(negedge clk); chk("R10 second line sets irq", host_irq_n, 1'b0);
        @(posedge clk); #1; irq_in = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); chk("R10 falling edge keeps irq", host_irq_n, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule